// File: doc/BRIEF.md
# Coherence Message Event Classifier

This block sits at the front of a private-cache coherence controller. Each incoming message is either a response (data, exclusive data, invalidation ack, writeback ack) or a request forwarded by the shared level (invalidate, exclusive or shared fetch by another core, instruction fetch by another core). The block turns each message into one controller event code, or into an error. It also owns a small table of outstanding misses. Each live entry keeps a signed count of acknowledgements still owed, together with the line data and dirty bit captured when the miss began.

A message arrives on a valid/ready channel, and its event leaves on a registered valid/ready channel one cycle later. The input can be accepted in any cycle where the output register is empty or is being drained, so `msg_ready = !ev_valid || ev_ready`. While `ev_ready` stays low, a waiting event holds all of its fields. Data and ack messages are classified against the entry named by `msg_slot`. The "last" variants are chosen when the stored count minus the message's ack count is zero, with the subtraction wrapping at CNT_W bits. The count may go negative when acks overtake the data that carries the expected total. Allocation, release and a read port for table state are plain control pins.

Top module: `coh_evclass`

## Requirements
- R1: A response of kind 1 (exclusive data) always yields event code 3, whatever the sender, line state or counts.
- R2: A response of kind 0 (data) with `msg_from_peer` and `msg_line_gets` both high yields code 2 and does not change the pending count.
- R3: Any other data response (kind 0) yields code 1 when pending minus `msg_acks` is zero, and code 0 otherwise.
- R4: A response of kind 2 (ack) yields code 5 when pending minus `msg_acks` is zero, and code 4 otherwise.
- R5: A response of kind 3 (writeback ack) yields code 6. Response kinds 4 to 7 raise `ev_err` with code 15.
- R6: On the forwarded channel (`msg_chan`=1), the kinds map as follows: 0 (invalidate) to code 7; 1 (exclusive fetch) and 2 (upgrade) both to code 8; 3 (shared fetch) to code 9; 4 (instruction fetch) to code 10. Kinds 5 to 7 raise `ev_err` with code 15.
- R7: Accepting a message that yields code 0, 1, 4 or 5 subtracts `msg_acks` from the pending count of `msg_slot`, wrapping at CNT_W bits. Every other event leaves the count unchanged.
- R8: `alloc_slot` shows the lowest-numbered free entry. An `alloc_req` when an entry is free makes that entry live at the next edge, with a pending count of zero and `alloc_data`/`alloc_dirty` captured.
- R9: `alloc_stall` is high exactly when `alloc_req` is high and every entry is live. A stalled request changes nothing.
- R10: `free_req` makes `free_slot` not live at the next edge. If that entry was already free, `tbl_err` is high for the cycle after.
- R11: `msg_ready` equals `!ev_valid || ev_ready`. An accepted message appears on `ev_valid`/`ev_code`/`ev_err` in the following cycle, and these stay unchanged until `ev_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Message present |
| msg_ready | output | 1 | Message accepted this cycle if valid |
| msg_chan | input | 1 | 0 = response, 1 = forwarded request |
| msg_kind | input | 3 | Message type code |
| msg_from_peer | input | 1 | Sender is another private cache |
| msg_line_gets | input | 1 | Line is waiting on a shared-read miss |
| msg_acks | input | CNT_W | Signed ack count carried by the message |
| msg_slot | input | SLOT_W | Miss-table entry of the line |
| ev_valid | output | 1 | Event present |
| ev_ready | input | 1 | Consumer takes the event |
| ev_code | output | 4 | Event code |
| ev_err | output | 1 | Message type was illegal |
| alloc_req | input | 1 | Open a miss entry |
| alloc_data | input | DATA_W | Line data to capture |
| alloc_dirty | input | 1 | Line dirty bit to capture |
| alloc_slot | output | SLOT_W | Entry that an allocation takes |
| alloc_stall | output | 1 | Allocation refused, table full |
| free_req | input | 1 | Release an entry |
| free_slot | input | SLOT_W | Entry to release |
| tbl_err | output | 1 | Previous release named a free entry |
| rd_slot | input | SLOT_W | Entry shown on the read port |
| rd_live | output | 1 | Entry is live |
| rd_pend | output | CNT_W | Signed pending count |
| rd_data | output | DATA_W | Captured data |
| rd_dirty | output | 1 | Captured dirty bit |

## Verification
The event fields are due one edge after the cycle in which a message is accepted. Table state on the read port, together with `tbl_err`, reflects the requests of the cycle before the latest edge. `msg_ready`, `alloc_slot` and `alloc_stall` are combinational and hold in the same cycle as their inputs. The bench drives inputs just after a rising edge and advances its reference model at that same edge. It compares every output at the falling edge, so the registered results are checked exactly one cycle after their cause and the combinational ones within the cycle.

// File: rtl/coh_evclass_pkg.sv
package coh_evclass_pkg;
  typedef enum logic [3:0] {
    EV_DATA       = 4'd0,
    EV_DATA_LAST  = 4'd1,
    EV_DATA_PEER  = 4'd2,
    EV_DATA_EXCL  = 4'd3,
    EV_ACK        = 4'd4,
    EV_ACK_LAST   = 4'd5,
    EV_WB_DONE    = 4'd6,
    EV_INV        = 4'd7,
    EV_FWD_EXCL   = 4'd8,
    EV_FWD_SHARED = 4'd9,
    EV_FWD_INSTR  = 4'd10,
    EV_NONE       = 4'd15
  } ev_code_e;

  localparam logic [2:0] RSP_DATA  = 3'd0;
  localparam logic [2:0] RSP_EXCL  = 3'd1;
  localparam logic [2:0] RSP_ACK   = 3'd2;
  localparam logic [2:0] RSP_WBACK = 3'd3;

  localparam logic [2:0] FWD_INV   = 3'd0;
  localparam logic [2:0] FWD_GETX  = 3'd1;
  localparam logic [2:0] FWD_UPGR  = 3'd2;
  localparam logic [2:0] FWD_GETS  = 3'd3;
  localparam logic [2:0] FWD_INSTR = 3'd4;
endpackage

// File: rtl/coh_evclass_decode.sv
module coh_evclass_decode
  import coh_evclass_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             chan,
  input  logic [2:0]       kind,
  input  logic             from_peer,
  input  logic             line_gets,
  input  logic [CNT_W-1:0] acks,
  input  logic [CNT_W-1:0] pend,
  output ev_code_e         code,
  output logic             err,
  output logic             consume
);
  logic signed [CNT_W-1:0] remain;
  logic                    last;

  always_comb begin
    remain  = $signed(pend) - $signed(acks);
    last    = (remain == '0);
    code    = EV_NONE;
    err     = 1'b0;
    consume = 1'b0;
    if (!chan) begin
      case (kind)
        RSP_DATA: begin
          if (from_peer && line_gets) begin
            code = EV_DATA_PEER;
          end else begin
            consume = 1'b1;
            code    = last ? EV_DATA_LAST : EV_DATA;
          end
        end
        RSP_EXCL:  code = EV_DATA_EXCL;
        RSP_ACK: begin
          consume = 1'b1;
          code    = last ? EV_ACK_LAST : EV_ACK;
        end
        RSP_WBACK: code = EV_WB_DONE;
        default:   err  = 1'b1;
      endcase
    end else begin
      case (kind)
        FWD_INV:             code = EV_INV;
        FWD_GETX, FWD_UPGR:  code = EV_FWD_EXCL;
        FWD_GETS:            code = EV_FWD_SHARED;
        FWD_INSTR:           code = EV_FWD_INSTR;
        default:             err  = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/coh_evclass_tbl.sv
module coh_evclass_tbl #(
  parameter int NSLOT  = 4,
  parameter int CNT_W  = 6,
  parameter int DATA_W = 16,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [SLOT_W-1:0] upd_slot,
  input  logic [CNT_W-1:0]  upd_acks,
  output logic [CNT_W-1:0]  upd_pend,
  input  logic              alloc_req,
  input  logic [DATA_W-1:0] alloc_data,
  input  logic              alloc_dirty,
  output logic [SLOT_W-1:0] alloc_slot,
  output logic              alloc_stall,
  input  logic              free_req,
  input  logic [SLOT_W-1:0] free_slot,
  output logic              tbl_err,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic              rd_live,
  output logic [CNT_W-1:0]  rd_pend,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_dirty
);
  logic [NSLOT-1:0]  live_q;
  logic [CNT_W-1:0]  pend_q  [NSLOT];
  logic [DATA_W-1:0] data_q  [NSLOT];
  logic [NSLOT-1:0]  dirty_q;
  logic              any_free;
  logic              alloc_go;

  always_comb begin
    alloc_slot = '0;
    any_free   = 1'b0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!live_q[i]) begin
        alloc_slot = SLOT_W'(i);
        any_free   = 1'b1;
      end
    end
  end

  assign alloc_stall = alloc_req && !any_free;
  assign alloc_go    = alloc_req && any_free;
  assign upd_pend    = pend_q[upd_slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= '0;
      dirty_q <= '0;
      tbl_err <= 1'b0;
      for (int i = 0; i < NSLOT; i++) begin
        pend_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      tbl_err <= free_req && !live_q[free_slot];
      for (int i = 0; i < NSLOT; i++) begin
        if (upd_en && upd_slot == SLOT_W'(i)) pend_q[i] <= pend_q[i] - upd_acks;
        if (free_req && free_slot == SLOT_W'(i)) live_q[i] <= 1'b0;
        if (alloc_go && alloc_slot == SLOT_W'(i)) begin
          live_q[i]  <= 1'b1;
          pend_q[i]  <= '0;
          data_q[i]  <= alloc_data;
          dirty_q[i] <= alloc_dirty;
        end
      end
    end
  end

  assign rd_live  = live_q[rd_slot];
  assign rd_pend  = pend_q[rd_slot];
  assign rd_data  = data_q[rd_slot];
  assign rd_dirty = dirty_q[rd_slot];
endmodule

// File: rtl/coh_evclass.sv
module coh_evclass
  import coh_evclass_pkg::*;
#(
  parameter int NSLOT  = 4,
  parameter int CNT_W  = 6,
  parameter int DATA_W = 16,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic              msg_chan,
  input  logic [2:0]        msg_kind,
  input  logic              msg_from_peer,
  input  logic              msg_line_gets,
  input  logic [CNT_W-1:0]  msg_acks,
  input  logic [SLOT_W-1:0] msg_slot,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [3:0]        ev_code,
  output logic              ev_err,
  input  logic              alloc_req,
  input  logic [DATA_W-1:0] alloc_data,
  input  logic              alloc_dirty,
  output logic [SLOT_W-1:0] alloc_slot,
  output logic              alloc_stall,
  input  logic              free_req,
  input  logic [SLOT_W-1:0] free_slot,
  output logic              tbl_err,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic              rd_live,
  output logic [CNT_W-1:0]  rd_pend,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_dirty
);
  logic             take;
  logic [CNT_W-1:0] cur_pend;
  ev_code_e         dec_code;
  logic             dec_err;
  logic             dec_consume;

  assign msg_ready = !ev_valid || ev_ready;
  assign take      = msg_valid && msg_ready;

  coh_evclass_decode #(.CNT_W(CNT_W)) u_dec (
    .chan      (msg_chan),
    .kind      (msg_kind),
    .from_peer (msg_from_peer),
    .line_gets (msg_line_gets),
    .acks      (msg_acks),
    .pend      (cur_pend),
    .code      (dec_code),
    .err       (dec_err),
    .consume   (dec_consume)
  );

  coh_evclass_tbl #(.NSLOT(NSLOT), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_tbl (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_en      (take && dec_consume),
    .upd_slot    (msg_slot),
    .upd_acks    (msg_acks),
    .upd_pend    (cur_pend),
    .alloc_req   (alloc_req),
    .alloc_data  (alloc_data),
    .alloc_dirty (alloc_dirty),
    .alloc_slot  (alloc_slot),
    .alloc_stall (alloc_stall),
    .free_req    (free_req),
    .free_slot   (free_slot),
    .tbl_err     (tbl_err),
    .rd_slot     (rd_slot),
    .rd_live     (rd_live),
    .rd_pend     (rd_pend),
    .rd_data     (rd_data),
    .rd_dirty    (rd_dirty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_valid <= 1'b0;
      ev_code  <= EV_NONE;
      ev_err   <= 1'b0;
    end else if (take) begin
      ev_valid <= 1'b1;
      ev_code  <= dec_code;
      ev_err   <= dec_err;
    end else if (ev_ready) begin
      ev_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/coh_evclass_chk.sv
module coh_evclass_chk
  import coh_evclass_pkg::*;
#(
  parameter int SLOT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic [3:0]        ev_code,
  input logic              ev_err,
  input logic              alloc_req,
  input logic [SLOT_W-1:0] alloc_slot,
  input logic              alloc_stall,
  input logic              free_req,
  input logic [SLOT_W-1:0] free_slot,
  input logic              tbl_err,
  input logic [SLOT_W-1:0] rd_slot,
  input logic              rd_live
);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_code) && $stable(ev_err));

  p_empty_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |-> msg_ready);

  p_take_emits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> ev_valid);

  p_err_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_err |-> ev_code == EV_NONE);

  p_stall_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_stall |-> alloc_req);

  p_alloc_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req && !alloc_stall |=> (rd_slot != $past(alloc_slot)) || rd_live);

  p_free_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    free_req && rd_slot == free_slot && !rd_live |=> tbl_err);
endmodule

bind coh_evclass coh_evclass_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .msg_valid   (msg_valid),
  .msg_ready   (msg_ready),
  .ev_valid    (ev_valid),
  .ev_ready    (ev_ready),
  .ev_code     (ev_code),
  .ev_err      (ev_err),
  .alloc_req   (alloc_req),
  .alloc_slot  (alloc_slot),
  .alloc_stall (alloc_stall),
  .free_req    (free_req),
  .free_slot   (free_slot),
  .tbl_err     (tbl_err),
  .rd_slot     (rd_slot),
  .rd_live     (rd_live)
);

// File: tb/coh_evclass_tb_top.sv
`timescale 1ns/1ps
module coh_evclass_tb_top;
  localparam int NS = 4;
  localparam int CW = 6;
  localparam int DW = 16;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          msg_valid = 0, msg_chan = 0, msg_from_peer = 0, msg_line_gets = 0;
  logic [2:0]    msg_kind = 0;
  logic [CW-1:0] msg_acks = 0;
  logic [SW-1:0] msg_slot = 0;
  logic          ev_ready = 1;
  logic          alloc_req = 0, alloc_dirty = 0;
  logic [DW-1:0] alloc_data = 0;
  logic          free_req = 0;
  logic [SW-1:0] free_slot = 0, rd_slot = 0;

  logic          msg_ready, ev_valid, ev_err, alloc_stall, tbl_err;
  logic          rd_live, rd_dirty;
  logic [3:0]    ev_code;
  logic [SW-1:0] alloc_slot;
  logic [CW-1:0] rd_pend;
  logic [DW-1:0] rd_data;

  coh_evclass #(.NSLOT(NS), .CNT_W(CW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_chan(msg_chan),
    .msg_kind(msg_kind), .msg_from_peer(msg_from_peer), .msg_line_gets(msg_line_gets),
    .msg_acks(msg_acks), .msg_slot(msg_slot),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_code(ev_code), .ev_err(ev_err),
    .alloc_req(alloc_req), .alloc_data(alloc_data), .alloc_dirty(alloc_dirty),
    .alloc_slot(alloc_slot), .alloc_stall(alloc_stall),
    .free_req(free_req), .free_slot(free_slot), .tbl_err(tbl_err),
    .rd_slot(rd_slot), .rd_live(rd_live), .rd_pend(rd_pend),
    .rd_data(rd_data), .rd_dirty(rd_dirty)
  );

  int total = 0;
  int bad = 0;
  bit checking = 0;

  // reference model state
  int m_live [NS];
  int m_pend [NS];
  int m_data [NS];
  int m_dirty [NS];
  int m_ev_v = 0, m_ev_c = 15, m_ev_e = 0, m_terr = 0;

  function automatic int wrapc(input int v);
    int m;
    m = v & ((1 << CW) - 1);
    return (m >= (1 << (CW - 1))) ? m - (1 << CW) : m;
  endfunction

  // classification from the requirement text; returns code, sets err/consume
  function automatic int classify(input int ch, input int k, input int peer,
                                  input int gets, input int acks, input int pend,
                                  output int err, output int cons);
    int last;
    err = 0; cons = 0;
    last = (wrapc(pend - acks) == 0);
    if (ch == 0) begin
      if (k == 1) return 3;                          // R1
      if (k == 0) begin
        if (peer != 0 && gets != 0) return 2;       // R2
        cons = 1; return last ? 1 : 0;               // R3
      end
      if (k == 2) begin cons = 1; return last ? 5 : 4; end  // R4
      if (k == 3) return 6;                          // R5
      err = 1; return 15;
    end
    if (k == 0) return 7;                            // R6
    if (k == 1 || k == 2) return 8;
    if (k == 3) return 9;
    if (k == 4) return 10;
    err = 1; return 15;
  endfunction

  function automatic string tag_of(input int code);
    case (code)
      3: return "R1";
      2: return "R2";
      0, 1: return "R3";
      4, 5: return "R4";
      6: return "R5";
      15: return "R5/R6";
      default: return "R6";
    endcase
  endfunction

  function automatic int low_free();
    for (int i = 0; i < NS; i++) if (m_live[i] == 0) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  initial for (int i = 0; i < NS; i++) begin
    m_live[i] = 0; m_pend[i] = 0; m_data[i] = 0; m_dirty[i] = 0;
  end

  // model advances on the same edge as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        m_live[i] = 0; m_pend[i] = 0; m_data[i] = 0; m_dirty[i] = 0;
      end
      m_ev_v = 0; m_ev_c = 15; m_ev_e = 0; m_terr = 0;
    end else begin
      int rdy, code, er, cons, lf, sl;
      rdy = (m_ev_v == 0 || ev_ready) ? 1 : 0;
      lf  = low_free();
      sl  = int'(msg_slot);
      code = classify(int'(msg_chan), int'(msg_kind), int'(msg_from_peer),
                      int'(msg_line_gets), wrapc(int'(msg_acks)), m_pend[sl], er, cons);
      if (msg_valid && rdy != 0) begin
        m_ev_v = 1; m_ev_c = code; m_ev_e = er;
        if (cons != 0) m_pend[sl] = wrapc(m_pend[sl] - wrapc(int'(msg_acks)));
      end else if (ev_ready) begin
        m_ev_v = 0;
      end
      m_terr = (free_req && m_live[int'(free_slot)] == 0) ? 1 : 0;
      if (free_req) m_live[int'(free_slot)] = 0;
      if (alloc_req && lf >= 0) begin
        m_live[lf] = 1; m_pend[lf] = 0;
        m_data[lf] = int'(alloc_data); m_dirty[lf] = int'(alloc_dirty);
      end
    end
  end

  // every output compared away from the active edge
  always @(negedge clk) begin
    if (checking) begin
      int lf, rs, exp_stall;
      lf = low_free();
      rs = int'(rd_slot);
      exp_stall = (alloc_req && lf < 0) ? 1 : 0;
      chk(int'(msg_ready) == ((m_ev_v == 0 || ev_ready) ? 1 : 0), "R11", "msg_ready",
          int'(msg_ready), (m_ev_v == 0 || ev_ready) ? 1 : 0);
      chk(int'(ev_valid) == m_ev_v, "R11", "ev_valid", int'(ev_valid), m_ev_v);
      if (m_ev_v != 0) begin
        chk(int'(ev_code) == m_ev_c, tag_of(m_ev_c), "ev_code", int'(ev_code), m_ev_c);
        chk(int'(ev_err) == m_ev_e, tag_of(m_ev_c), "ev_err", int'(ev_err), m_ev_e);
      end
      if (lf >= 0)
        chk(int'(alloc_slot) == lf, "R8", "alloc_slot", int'(alloc_slot), lf);
      chk(int'(alloc_stall) == exp_stall, "R9", "alloc_stall", int'(alloc_stall), exp_stall);
      chk(int'(tbl_err) == m_terr, "R10", "tbl_err", int'(tbl_err), m_terr);
      chk(int'(rd_live) == m_live[rs], "R8/R10", "rd_live", int'(rd_live), m_live[rs]);
      chk(wrapc(int'(rd_pend)) == m_pend[rs], "R7", "rd_pend",
          wrapc(int'(rd_pend)), m_pend[rs]);
      if (m_live[rs] != 0) begin
        chk(int'(rd_data) == m_data[rs], "R8", "rd_data", int'(rd_data), m_data[rs]);
        chk(int'(rd_dirty) == m_dirty[rs], "R8", "rd_dirty", int'(rd_dirty), m_dirty[rs]);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(input int ch, input int k, input int peer, input int gets,
                      input int acks, input int sl);
    msg_valid = 1; msg_chan = ch[0]; msg_kind = k[2:0];
    msg_from_peer = peer[0]; msg_line_gets = gets[0];
    msg_acks = CW'(acks); msg_slot = SW'(sl); rd_slot = SW'(sl);
    tick();
    msg_valid = 0;
  endtask

  task automatic alloc(input int d, input int dirty);
    alloc_req = 1; alloc_data = DW'(d); alloc_dirty = dirty[0];
    tick();
    alloc_req = 0;
  endtask

  task automatic release_slot(input int sl);
    free_req = 1; free_slot = SW'(sl); rd_slot = SW'(sl);
    tick();
    free_req = 0;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 checking = 1;        // reset state compared from here on
    rst_n = 1;
    tick();

    // R8: three allocations take slots 0,1,2
    for (int i = 0; i < 3; i++) begin
      rd_slot = SW'(i);
      alloc(16'hA5A0 + i, i % 2);
    end

    // R4, R7: ack overtakes data, count goes negative
    send(0, 2, 0, 0, 1, 0);          // 0-1 != 0 -> ack (4), pend -1
    // R3: data carrying -1 finishes: -1-(-1)=0 -> last (1)
    send(0, 0, 0, 0, -1, 0);
    send(0, 0, 0, 0, 2, 1);          // R3 -> data (0), pend -2
    send(0, 2, 0, 0, -1, 1);         // R4 -> ack, pend -1
    send(0, 2, 0, 0, -1, 1);         // R4 -> ack last (5), pend 0
    // R2: peer data in GETS wait, count untouched
    send(0, 0, 1, 1, 3, 2);
    send(0, 0, 1, 0, 0, 2);          // R3 not peer case -> last
    send(0, 0, 0, 1, 1, 2);          // R3 -> data, pend -1
    send(0, 1, 1, 1, 7, 2);          // R1
    send(0, 3, 0, 0, 0, 2);          // R5
    for (int k = 4; k < 8; k++) send(0, k, 0, 0, 0, 2);  // R5 errors
    for (int k = 0; k < 8; k++) send(1, k, 0, 0, 0, 2);  // R6

    // R11: back-pressure holds the event and stops intake
    ev_ready = 0;
    msg_valid = 1; msg_chan = 1; msg_kind = 3'd3;
    tick();
    msg_kind = 3'd0;
    repeat (3) tick();
    ev_ready = 1;
    tick();
    msg_valid = 0;
    tick();

    // R9: fill and stall
    rd_slot = 3;
    alloc(16'h1234, 1);
    alloc(16'h5555, 0);
    // R10: release twice, second flags error
    release_slot(1);
    release_slot(1);
    // alloc and free in one cycle
    alloc_req = 1; alloc_data = 16'h0BEE; alloc_dirty = 1;
    free_req = 1; free_slot = 2; rd_slot = 1;
    tick();
    alloc_req = 0; free_req = 0;
    tick();

    // mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      msg_valid     = ($urandom % 3) != 0;
      msg_chan      = 1'($urandom % 2);
      msg_kind      = 3'($urandom % 8);
      msg_from_peer = 1'($urandom % 2);
      msg_line_gets = 1'($urandom % 2);
      msg_acks      = CW'(int'($urandom % 5) - 2);
      msg_slot      = SW'($urandom % NS);
      ev_ready      = ($urandom % 4) != 0;
      alloc_req     = ($urandom % 4) == 0;
      alloc_data    = DW'($urandom);
      alloc_dirty   = 1'($urandom % 2);
      free_req      = ($urandom % 5) == 0;
      free_slot     = SW'($urandom % NS);
      rd_slot       = SW'($urandom % NS);
      tick();
    end
    msg_valid = 0; alloc_req = 0; free_req = 0; ev_ready = 1;
    repeat (2) tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule